// File: doc/BRIEF.md
# Cache write stream sequencer

This block sits on the write side of a data cache controller and turns pipeline write traffic into a stream of 33-bit words: 32 data bits plus one control bit. The words go into an outgoing FIFO-style channel that raises a full flag when it cannot take more. Every transfer starts with an address word and is followed by its data. Burst, word, halfword and byte writes share the one channel. The consumer tells them apart only by the two least-significant address bits and by the control bit on the first data word.

The write policy is fixed at build time by the `WRITE_BACK` parameter.

- **Write-through build.** Every store request becomes one single-beat write, whatever its hit or miss status in the cache.
- **Write-back build.** Stores stay in the cache and produce no traffic. A line flush whose line is fully valid is sent as a burst of `LINE_WORDS` data words.

The pipeline sees `busy` as its stall signal. A request is taken only while the block is idle.

Top module: `cache_wr_seq`

## Requirements
- R1: No word is pushed (`outWrite` high) in a cycle where `outFull` is high. The pending word and its control bit are held unchanged until the flag drops.
- R2: The first word of every transfer is the address word, and its control bit is 1.
- R3: A burst address word is the flush address with the line-offset bits cleared and bits [1:0] set to 2'b10.
- R4: A burst sends exactly `LINE_WORDS` data words after the address. Each carries control bit 0. They go in ascending word-address order, and word i is taken from `flushLine[32*i +: 32]`.
- R5: In a single write, bits [31:2] of the address word equal those of the store address. Bits [1:0] are set from `storeSize` (0 = byte, 1 = halfword, 2 or 3 = word):
  - byte: the store address bits [1:0];
  - halfword: {address bit 1, 1'b1};
  - word: 2'b00.
- R6: The data word of a single byte write carries control bit 1. A halfword or word write carries control bit 0.
- R7: The outgoing data is built from the low bits of `storeData`:
  - byte: `storeData[7:0]` repeated on all four byte lanes;
  - halfword: `storeData[15:0]` repeated on both halfword lanes;
  - word: `storeData` unchanged.
- R8: In the write-through build each accepted store produces exactly one address word and one data word, and flush requests produce no traffic.
- R9: In the write-back build a burst starts only on a flush request with `flushLineFull` high. Store requests and flushes of a partly valid line produce no traffic.
- R10: After reset `busy` and `outWrite` are low. `busy` rises in the cycle after a request is accepted and falls after the last word is pushed. Requests made while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| storeReq | input | 1 | Store request, taken when idle |
| storeAddr | input | 32 | Byte address of the store |
| storeData | input | 32 | Store data, right aligned for byte and halfword |
| storeSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| flushReq | input | 1 | Line flush request, taken when idle |
| flushLineFull | input | 1 | Every word of the flushed line is valid |
| flushAddr | input | 32 | Any byte address inside the flushed line |
| flushLine | input | 32*LINE_WORDS | Line data, word 0 in the low bits |
| outFull | input | 1 | Outgoing channel cannot accept a word |
| outData | output | 32 | Outgoing word |
| outCtrl | output | 1 | Control bit of the outgoing word |
| outWrite | output | 1 | Word pushed this cycle |
| busy | output | 1 | Transfer in progress, stall the pipeline |

## Verification
The assertions take for granted that `outFull` is a level the consumer may raise or drop in any cycle. They also assume that nothing about the request inputs matters while `busy` is high, since the block ignores them then.

The byte-mirror property relies on a single transfer in the write-through build being the only source of a data word with control bit 1. The stimulus keeps within these assumptions:
- it changes every input one nanosecond after a rising edge;
- it uses only size codes 0 to 2;
- it checks the `outFull` stall both as a long hold and as a level that toggles every cycle inside a burst.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } storeSize_t;

  typedef struct packed {
    logic loadSingle;
    logic loadBurst;
    logic sendAddr;
    logic shift;
  } ctlStrobe_t;
endpackage

// File: rtl/cws_ctrl.sv
module cws_ctrl
  import cws_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       storeReq,
  input  logic       flushReq,
  input  logic       flushLineFull,
  input  logic       outFull,
  output ctlStrobe_t strobe,
  output logic       outWrite,
  output logic       busy
);
  localparam int CNT_W = $clog2(LINE_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} state_t;

  state_t           state;
  logic             isBurst;
  logic [CNT_W-1:0] wordCnt;
  logic             acceptSingle, acceptBurst, push, lastData;

  assign acceptSingle = (state == ST_IDLE) && storeReq && !WRITE_BACK;
  assign acceptBurst  = (state == ST_IDLE) && flushReq && flushLineFull && WRITE_BACK;
  assign push         = (state != ST_IDLE) && !outFull;
  assign lastData     = !isBurst || (wordCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isBurst <= 1'b0;
      wordCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (acceptSingle || acceptBurst) begin
          state   <= ST_ADDR;
          isBurst <= acceptBurst;
        end
        ST_ADDR: if (push) begin
          state   <= ST_DATA;
          wordCnt <= '0;
        end
        ST_DATA: if (push) begin
          if (lastData) state <= ST_IDLE;
          else          wordCnt <= wordCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadSingle = acceptSingle;
    strobe.loadBurst  = acceptBurst;
    strobe.sendAddr   = (state == ST_ADDR);
    strobe.shift      = (state == ST_DATA) && push && isBurst;
  end

  assign outWrite = push;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/cws_datapath.sv
module cws_datapath
  import cws_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   strobe,
  input  logic [WORD_W-1:0]            storeAddr,
  input  logic [WORD_W-1:0]            storeData,
  input  logic [1:0]                   storeSize,
  input  logic [WORD_W-1:0]            flushAddr,
  input  logic [WORD_W*LINE_WORDS-1:0] flushLine,
  output logic [WORD_W-1:0]            outData,
  output logic                         outCtrl
);
  localparam int LINE_OFF = $clog2(LINE_WORDS) + 2;

  logic [WORD_W-1:0] addrWord;
  logic              dataCtrl;
  logic [WORD_W-1:0] lineBuf [LINE_WORDS];
  logic [1:0]        laneCode;
  logic [WORD_W-1:0] mirrored;
  logic [WORD_W-1:0] burstAddr;

  always_comb begin
    unique case (storeSize)
      SZ_BYTE: begin laneCode = storeAddr[1:0];         mirrored = {4{storeData[7:0]}};  end
      SZ_HALF: begin laneCode = {storeAddr[1], 1'b1};   mirrored = {2{storeData[15:0]}}; end
      default: begin laneCode = 2'b00;                  mirrored = storeData;            end
    endcase
    burstAddr = {flushAddr[WORD_W-1:LINE_OFF], {(LINE_OFF-2){1'b0}}, 2'b10};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrWord <= '0;
      dataCtrl <= 1'b0;
    end else if (strobe.loadSingle) begin
      addrWord <= {storeAddr[WORD_W-1:2], laneCode};
      dataCtrl <= (storeSize == SZ_BYTE);
    end else if (strobe.loadBurst) begin
      addrWord <= burstAddr;
      dataCtrl <= 1'b0;
    end
  end

  for (genvar i = 0; i < LINE_WORDS; i++) begin : gSlot
    logic [WORD_W-1:0] nextWord;
    if (i == LINE_WORDS - 1) begin : gTail
      assign nextWord = '0;
    end else begin : gMid
      assign nextWord = lineBuf[i+1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             lineBuf[i] <= '0;
      else if (strobe.loadBurst)             lineBuf[i] <= flushLine[WORD_W*i +: WORD_W];
      else if (strobe.loadSingle && i == 0)  lineBuf[i] <= mirrored;
      else if (strobe.shift)                 lineBuf[i] <= nextWord;
    end
  end

  assign outData = strobe.sendAddr ? addrWord : lineBuf[0];
  assign outCtrl = strobe.sendAddr ? 1'b1 : dataCtrl;
endmodule

// File: rtl/cache_wr_seq.sv
module cache_wr_seq
  import cws_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     storeReq,
  input  logic [31:0]              storeAddr,
  input  logic [31:0]              storeData,
  input  logic [1:0]               storeSize,
  input  logic                     flushReq,
  input  logic                     flushLineFull,
  input  logic [31:0]              flushAddr,
  input  logic [32*LINE_WORDS-1:0] flushLine,
  input  logic                     outFull,
  output logic [31:0]              outData,
  output logic                     outCtrl,
  output logic                     outWrite,
  output logic                     busy
);
  ctlStrobe_t strobe;

  cws_ctrl #(.LINE_WORDS(LINE_WORDS), .WRITE_BACK(WRITE_BACK)) uCtrl (
    .clk(clk), .rstN(rstN), .storeReq(storeReq), .flushReq(flushReq),
    .flushLineFull(flushLineFull), .outFull(outFull), .strobe(strobe),
    .outWrite(outWrite), .busy(busy)
  );

  cws_datapath #(.LINE_WORDS(LINE_WORDS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .storeAddr(storeAddr),
    .storeData(storeData), .storeSize(storeSize), .flushAddr(flushAddr),
    .flushLine(flushLine), .outData(outData), .outCtrl(outCtrl)
  );
endmodule

// File: rtl/cws_checker.sv
module cws_checker #(
  parameter int LINE_WORDS = 4,
  parameter bit WRITE_BACK = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic        outFull,
  input logic [31:0] outData,
  input logic        outCtrl,
  input logic        outWrite,
  input logic        busy
);
  localparam int LINE_OFF = $clog2(LINE_WORDS) + 2;
  localparam int MAX_PUSH = WRITE_BACK ? LINE_WORDS + 1 : 2;

  logic [7:0] pushIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pushIdx <= '0;
    else if (!busy)    pushIdx <= '0;
    else if (outWrite) pushIdx <= pushIdx + 1'b1;
  end

  a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    outFull |-> !outWrite);
  a_r1_hold_while_full: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && busy) |=> busy && $stable(outData) && $stable(outCtrl));
  a_r2_addr_first: assert property (@(posedge clk) disable iff (!rstN)
    (outWrite && pushIdx == 8'd0) |-> outCtrl);
  a_r3_burst_addr: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK && outWrite && pushIdx == 8'd0) |->
      (outData[1:0] == 2'b10 && outData[LINE_OFF-1:2] == '0));
  a_r4_burst_data_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK && outWrite && pushIdx != 8'd0) |-> !outCtrl);
  a_r7_byte_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (!WRITE_BACK && outWrite && pushIdx == 8'd1 && outCtrl) |->
      (outData[31:16] == outData[15:0] && outData[15:8] == outData[7:0]));
  a_r8_push_count: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |-> (pushIdx < 8'(MAX_PUSH)));
  a_r10_no_push_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outWrite);
endmodule

bind cache_wr_seq cws_checker #(.LINE_WORDS(LINE_WORDS), .WRITE_BACK(WRITE_BACK)) uChk (
  .clk(clk), .rstN(rstN), .outFull(outFull), .outData(outData),
  .outCtrl(outCtrl), .outWrite(outWrite), .busy(busy)
);

// File: tb/sim_cache_wr_seq.sv
`timescale 1ns/1ps
module sim_cache_wr_seq;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          sReqA, sReqB, fReqA, fReqB, fFullA, fFullB, fullA, fullB;
  logic [31:0]   sAddr, sData, fAddr;
  logic [1:0]    sSize;
  logic [32*LW-1:0] fLine;
  logic [31:0]   dA, dB;
  logic          cA, cB, wA, wB, bA, bB;

  cache_wr_seq #(.LINE_WORDS(LW), .WRITE_BACK(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .storeReq(sReqA), .storeAddr(sAddr), .storeData(sData),
    .storeSize(sSize), .flushReq(fReqA), .flushLineFull(fFullA), .flushAddr(fAddr),
    .flushLine(fLine), .outFull(fullA), .outData(dA), .outCtrl(cA), .outWrite(wA), .busy(bA));

  cache_wr_seq #(.LINE_WORDS(LW), .WRITE_BACK(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .storeReq(sReqB), .storeAddr(sAddr), .storeData(sData),
    .storeSize(sSize), .flushReq(fReqB), .flushLineFull(fFullB), .flushAddr(fAddr),
    .flushLine(fLine), .outFull(fullB), .outData(dB), .outCtrl(cB), .outWrite(wB), .busy(bB));

  logic [32:0] capA [256];
  logic [32:0] capB [256];
  int nA = 0, nB = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (wA && nA < 256) begin capA[nA] = {cA, dA}; nA++; end
    if (wB && nB < 256) begin capB[nB] = {cB, dB}; nB++; end
  end

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitIdle(input bit onB);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (!(onB ? bB : bA)) break;
    end
  endtask

  task automatic storeA(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz);
    sAddr = a; sData = d; sSize = sz; sReqA = 1'b1;
    @(posedge clk); #1; sReqA = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 busy after reset", {32'd0, bA}, 33'd0);
    chk("R10 outWrite after reset", {32'd0, wB}, 33'd0);
  endtask

  task automatic t_word();
    int base = nA;
    storeA(32'h1000_0007, 32'hDEAD_BEEF, 2'd2);
    chk("R10 busy after accept", {32'd0, bA}, 33'd1);
    waitIdle(1'b0);
    chk("R8 word count", 33'(nA - base), 33'd2);
    chk("R2 R5 word addr", capA[base], {1'b1, 32'h1000_0004});
    chk("R6 R7 word data", capA[base+1], {1'b0, 32'hDEAD_BEEF});
  endtask

  task automatic t_bytes();
    for (int k = 0; k < 4; k++) begin
      int base = nA;
      logic [7:0] b = 8'h5A + 8'(k);
      storeA(32'h2000_0010 + 32'(k), {24'hABCDEF, b}, 2'd0);
      waitIdle(1'b0);
      chk("R5 byte lane code", capA[base], {1'b1, 32'h2000_0010 + 32'(k)});
      chk("R6 R7 byte ctrl and mirror", capA[base+1], {1'b1, {4{b}}});
    end
  endtask

  task automatic t_halves();
    for (int k = 0; k < 2; k++) begin
      int base = nA;
      logic [15:0] h = 16'h1234 + 16'(k);
      storeA(32'h3000_0020 + 32'(2*k), {16'hFFFF, h}, 2'd1);
      waitIdle(1'b0);
      chk("R5 halfword lane code", capA[base], {1'b1, 32'h3000_0021 + 32'(2*k)});
      chk("R6 R7 halfword ctrl and mirror", capA[base+1], {1'b0, {2{h}}});
    end
  endtask

  task automatic t_stall();
    int base = nA;
    fullA = 1'b1;
    storeA(32'h4000_0000, 32'h0BAD_F00D, 2'd2);
    repeat (5) @(posedge clk);
    #1;
    chk("R1 no push while full", 33'(nA - base), 33'd0);
    chk("R10 busy held while full", {32'd0, bA}, 33'd1);
    storeA(32'h5000_0000, 32'h1111_1111, 2'd2);
    fullA = 1'b0;
    waitIdle(1'b0);
    repeat (4) @(posedge clk);
    #1;
    chk("R10 request during busy dropped", 33'(nA - base), 33'd2);
    chk("R1 addr after release", capA[base], {1'b1, 32'h4000_0000});
    chk("R1 data after release", capA[base+1], {1'b0, 32'h0BAD_F00D});
  endtask

  task automatic t_flushWt();
    int base = nA;
    fAddr = 32'h6000_0000; fFullA = 1'b1; fReqA = 1'b1;
    @(posedge clk); #1; fReqA = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    chk("R8 flush ignored in write-through", 33'(nA - base), 33'd0);
    chk("R8 busy stays low", {32'd0, bA}, 33'd0);
  endtask

  task automatic t_burst(input bit toggleFull);
    int base = nB;
    for (int i = 0; i < LW; i++) fLine[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 17) + (toggleFull ? 32'h100 : 0);
    fAddr = toggleFull ? 32'h7000_0108 : 32'h7000_0034;
    fFullB = 1'b1; fReqB = 1'b1;
    @(posedge clk); #1; fReqB = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (toggleFull) fullB = ~fullB;
      @(posedge clk); #1;
      if (!bB) break;
    end
    fullB = 1'b0;
    chk("R4 burst length", 33'(nB - base), 33'(LW + 1));
    chk("R2 R3 burst addr", capB[base], {1'b1, toggleFull ? 32'h7000_0102 : 32'h7000_0032});
    for (int i = 0; i < LW; i++)
      chk("R4 burst data order", capB[base+1+i], {1'b0, fLine[32*i +: 32]});
  endtask

  task automatic t_wbIgnored();
    int base = nB;
    sAddr = 32'h8000_0000; sData = 32'h2222_2222; sSize = 2'd2; sReqB = 1'b1;
    @(posedge clk); #1; sReqB = 1'b0;
    fAddr = 32'h8000_0040; fFullB = 1'b0; fReqB = 1'b1;
    @(posedge clk); #1; fReqB = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    chk("R9 store and partial flush silent", 33'(nB - base), 33'd0);
    chk("R9 busy stays low", {32'd0, bB}, 33'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    sReqA = 0; sReqB = 0; fReqA = 0; fReqB = 0; fFullA = 0; fFullB = 0;
    fullA = 0; fullB = 0; sAddr = 0; sData = 0; sSize = 0; fAddr = 0; fLine = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_word();
    t_bytes();
    t_halves();
    t_stall();
    t_flushWt();
    t_burst(1'b0);
    t_burst(1'b1);
    t_wbIgnored();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule